// File: doc/BRIEF.md
# DMA transfer length sequencer

This block runs the data-transfer phase of a bus controller. When software strobes a start, it builds a 16-bit transfer count from two programmed bytes. It then clips that count against a limit that depends on the bus phase. The result is a single DMA burst request toward an external memory port, with a direction attached. The block tracks how much of the phase is still outstanding. When the transfer ends it updates the terminal-count flag, the interrupt code and the remaining count, and raises an interrupt.

The remaining-phase length is a signed number. A negative value means the bytes travel toward the device; zero or a positive value means they come from it. In command phase the burst is capped at a small fixed size. A burst is held off while the device-side buffer is empty. After the burst is acknowledged, the block either completes at once or waits for the device side to supply more data. A separate path holds a selection command that arrives while DMA is disabled and releases it once DMA is enabled.

Top module: `xfer_len_seq`

## Requirements
- R1: The transfer count is `{cnt_mid, cnt_lo}` (mid byte in bits 15:8, low byte in bits 7:0); a count of 0 stands for 65536 bytes.
- R2: With `cmd_phase` high at start, the burst length is the smaller of the count and 32, `burst_to_dev` is 1, and `rem_len` is left unchanged by the acknowledge.
- R3: With `cmd_phase` low, a negative `phase_len` gives `burst_to_dev`=1 and a burst of min(count, -phase_len); a zero or positive value gives `burst_to_dev`=0 and min(count, phase_len); the direction holds until the next start.
- R4: In the cycle after a start whose burst length is nonzero, `tc_flag` is 0, `done` is 0 and `burst_len` shows the clipped length.
- R5: `burst_req` is high only while a transfer is pending an acknowledge and `dev_empty` is 0; while `dev_empty` is 1 the request waits.
- R6: An accepted `burst_ack` moves `rem_len` toward zero by `ack_bytes`: it adds for a toward-device transfer and subtracts for a from-device transfer. In command phase it is not changed.
- R7: At the acknowledge, the transfer completes in that cycle in any of these cases: `dev_empty` is 0 (buffer left partly filled), the direction is toward the device, unacknowledged count remains, or the updated `rem_len` is zero. Otherwise it defers.
- R8: A deferred transfer raises no `done` and no `burst_req` while `dev_empty` stays 1. It completes in the cycle after `dev_empty` falls to 0.
- R9: Completion pulses `done` for one cycle and sets `tc_flag`=1, `irq`=1, `intr_reg`=8'h10 (bus service) and `burst_len`=0. `irq_clear` clears `irq` and `intr_reg` to 0.
- R10: A start whose clipped length is zero completes at the start edge with the R9 effects and makes no request.
- R11: A `sel_req` with `dma_en` high gives a one-cycle `sel_go` the next cycle. With `dma_en` low it is held with no `sel_go`, and `sel_go` pulses the cycle after `dma_en` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for the transfer phase |
| cnt_lo | input | 8 | Programmed count, low byte |
| cnt_mid | input | 8 | Programmed count, mid byte |
| phase_len | input | LEN_W (24) | Signed remaining phase length |
| cmd_phase | input | 1 | Bus is in command phase |
| dma_en | input | 1 | DMA enable level |
| sel_req | input | 1 | Selection command strobe |
| dev_empty | input | 1 | Device-side buffer is empty |
| burst_ack | input | 1 | Burst acknowledge strobe |
| ack_bytes | input | CNT_W (17) | Bytes moved by the acknowledged burst |
| irq_clear | input | 1 | Clears the interrupt and its code |
| burst_req | output | 1 | Burst request |
| burst_len | output | CNT_W (17) | Burst length / remaining count |
| burst_to_dev | output | 1 | 1 = memory to device |
| done | output | 1 | One-cycle completion strobe |
| irq | output | 1 | Interrupt line |
| tc_flag | output | 1 | Terminal-count status flag |
| intr_reg | output | 8 | Interrupt code |
| rem_len | output | LEN_W (24) | Signed remaining phase length |
| sel_go | output | 1 | Released selection strobe |

## Verification
The hardest state to reach from the ports is the deferred completion. It needs a from-device transfer outside command phase whose acknowledge consumes the whole clipped count, leaves the buffer empty and still leaves a nonzero phase length. The sweep reaches it by pairing positive lengths larger than the count with full acknowledges on alternating `dev_empty` settings. It then holds `dev_empty` high for a cycle before releasing it. Zero-length starts, which complete without any request, come from the zero phase length in the same sweep.

// File: rtl/xls_pkg.sv
package xls_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} xls_state_e;

  // count from two bytes, zero meaning the full 64 KiB
  function automatic int unsigned xls_count(input logic [7:0] lo, input logic [7:0] mid);
    int unsigned v;
    v = {16'd0, mid, lo};
    return (v == 0) ? 32'd65536 : v;
  endfunction

  // clip the count by the phase-dependent limit
  function automatic int unsigned xls_burst(input int unsigned cnt, input int plen,
                                            input logic cmd, input int unsigned cap);
    int unsigned lim;
    if (cmd)           lim = cap;
    else if (plen < 0) lim = unsigned'(-plen);
    else               lim = unsigned'(plen);
    return (cnt < lim) ? cnt : lim;
  endfunction

endpackage

// File: rtl/xls_len_calc.sv
module xls_len_calc
  import xls_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int CNT_W   = 17,
  parameter int CMD_CAP = 32
) (
  input  logic [7:0]              cnt_lo,
  input  logic [7:0]              cnt_mid,
  input  logic signed [LEN_W-1:0] phase_len,
  input  logic                    cmd_phase,
  output logic [CNT_W-1:0]        len,
  output logic                    to_dev,
  output logic                    zero_len
);
  int unsigned cnt_full;
  int          plen_i;

  always_comb begin
    cnt_full = xls_count(cnt_lo, cnt_mid);
    plen_i   = int'(phase_len);
    len      = CNT_W'(xls_burst(cnt_full, plen_i, cmd_phase, CMD_CAP));
    to_dev   = cmd_phase | phase_len[LEN_W-1];
    zero_len = (len == '0);
  end

  // R2: command-phase bursts never exceed the cap
  always_comb begin
    if (cmd_phase) begin
      assert_cmd_cap_R2: assert (len <= CNT_W'(CMD_CAP));
    end
  end

endmodule

// File: rtl/xls_sel_hold.sv
module xls_sel_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  input  logic dma_en,
  output logic sel_go
);
  logic pending_q;
  logic go_q;
  logic want;

  assign want   = pending_q | sel_req;
  assign sel_go = go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      go_q      <= want & dma_en;
      pending_q <= want & ~dma_en;
    end
  end

  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !dma_en) |=> !sel_go);

  assert_sel_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_go |-> $past(dma_en));

endmodule

// File: rtl/xls_ctrl.sv
module xls_ctrl
  import xls_pkg::*;
#(
  parameter int          LEN_W   = 24,
  parameter int          CNT_W   = 17,
  parameter logic [7:0]  BS_CODE = 8'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        calc_len,
  input  logic                    calc_to_dev,
  input  logic                    calc_zero,
  input  logic                    cmd_phase,
  input  logic signed [LEN_W-1:0] phase_len,
  input  logic                    dev_empty,
  input  logic                    burst_ack,
  input  logic [CNT_W-1:0]        ack_bytes,
  input  logic                    irq_clear,
  output logic                    burst_req,
  output logic [CNT_W-1:0]        burst_len,
  output logic                    burst_to_dev,
  output logic                    done,
  output logic                    irq,
  output logic                    tc_flag,
  output logic [7:0]              intr_reg,
  output logic signed [LEN_W-1:0] rem_len
);
  xls_state_e              state;
  logic [CNT_W-1:0]        left_q;
  logic                    to_dev_q;
  logic                    cmd_q;
  logic signed [LEN_W-1:0] rem_q;
  logic                    done_q, irq_q, tc_q;
  logic [7:0]              intr_q;

  // named internal events
  logic signed [LEN_W-1:0] ack_s;
  logic signed [LEN_W-1:0] rem_after;
  logic [CNT_W-1:0]        left_after;
  logic                    ack_take, finish_now, wake, complete;

  assign ack_s      = LEN_W'(ack_bytes);
  assign rem_after  = cmd_q ? rem_q : (to_dev_q ? rem_q + ack_s : rem_q - ack_s);
  assign left_after = left_q - ack_bytes;
  assign ack_take   = (state == ST_REQ) && burst_ack && !start;
  assign finish_now = ack_take &&
                      (!dev_empty || to_dev_q || (left_after != '0) || (rem_after == '0));
  assign wake       = (state == ST_WAIT) && !dev_empty && !start;
  assign complete   = finish_now || wake || (start && calc_zero);

  assign burst_req    = (state == ST_REQ) && !dev_empty;
  assign burst_len    = left_q;
  assign burst_to_dev = to_dev_q;
  assign done         = done_q;
  assign irq          = irq_q;
  assign tc_flag      = tc_q;
  assign intr_reg     = intr_q;
  assign rem_len      = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      left_q   <= '0;
      to_dev_q <= 1'b0;
      cmd_q    <= 1'b0;
      rem_q    <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      tc_q     <= 1'b0;
      intr_q   <= '0;
    end else begin
      done_q <= complete;
      if (start) begin
        to_dev_q <= calc_to_dev;
        cmd_q    <= cmd_phase;
        rem_q    <= phase_len;
        left_q   <= calc_len;
        tc_q     <= 1'b0;
        state    <= calc_zero ? ST_IDLE : ST_REQ;
      end else if (ack_take) begin
        rem_q  <= rem_after;
        left_q <= left_after;
        state  <= finish_now ? ST_IDLE : ST_WAIT;
      end else if (wake) begin
        state <= ST_IDLE;
      end
      if (complete) begin
        tc_q   <= 1'b1;
        irq_q  <= 1'b1;
        intr_q <= BS_CODE;
        left_q <= '0;
      end else if (irq_clear) begin
        irq_q  <= 1'b0;
        intr_q <= '0;
      end
    end
  end

  assert_tc_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !calc_zero) |=> !tc_flag);

  assert_done_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc_flag && irq && burst_len == '0 && intr_reg == BS_CODE));

  assert_req_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (burst_len != '0));

  assert_dir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && state != ST_IDLE) |=> $stable(burst_to_dev));

  assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && dev_empty && !start) |=> (!done && !burst_req));

endmodule

// File: rtl/xfer_len_seq.sv
module xfer_len_seq #(
  parameter int         LEN_W   = 24,
  parameter int         CNT_W   = 17,
  parameter int         CMD_CAP = 32,
  parameter logic [7:0] BS_CODE = 8'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              cnt_lo,
  input  logic [7:0]              cnt_mid,
  input  logic signed [LEN_W-1:0] phase_len,
  input  logic                    cmd_phase,
  input  logic                    dma_en,
  input  logic                    sel_req,
  input  logic                    dev_empty,
  input  logic                    burst_ack,
  input  logic [CNT_W-1:0]        ack_bytes,
  input  logic                    irq_clear,
  output logic                    burst_req,
  output logic [CNT_W-1:0]        burst_len,
  output logic                    burst_to_dev,
  output logic                    done,
  output logic                    irq,
  output logic                    tc_flag,
  output logic [7:0]              intr_reg,
  output logic signed [LEN_W-1:0] rem_len,
  output logic                    sel_go
);
  logic [CNT_W-1:0] calc_len;
  logic             calc_to_dev;
  logic             calc_zero;

  xls_len_calc #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CMD_CAP(CMD_CAP)) u_calc (
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .phase_len(phase_len), .cmd_phase(cmd_phase),
    .len(calc_len), .to_dev(calc_to_dev), .zero_len(calc_zero)
  );

  xls_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BS_CODE(BS_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .calc_len(calc_len), .calc_to_dev(calc_to_dev), .calc_zero(calc_zero),
    .cmd_phase(cmd_phase), .phase_len(phase_len), .dev_empty(dev_empty),
    .burst_ack(burst_ack), .ack_bytes(ack_bytes), .irq_clear(irq_clear),
    .burst_req(burst_req), .burst_len(burst_len), .burst_to_dev(burst_to_dev),
    .done(done), .irq(irq), .tc_flag(tc_flag), .intr_reg(intr_reg), .rem_len(rem_len)
  );

  xls_sel_hold u_sel (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .dma_en(dma_en), .sel_go(sel_go)
  );

endmodule

// File: tb/xfer_len_seq_test.sv
module xfer_len_seq_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [7:0]         cnt_lo = '0, cnt_mid = '0;
  logic signed [23:0] phase_len = '0;
  logic               cmd_phase = 1'b0, dma_en = 1'b0, sel_req = 1'b0;
  logic               dev_empty = 1'b1, burst_ack = 1'b0, irq_clear = 1'b0;
  logic [16:0]        ack_bytes = '0;
  logic               burst_req, burst_to_dev, done, irq, tc_flag, sel_go;
  logic [16:0]        burst_len;
  logic [7:0]         intr_reg;
  logic signed [23:0] rem_len;

  int checks = 0;
  int fails  = 0;

  xfer_len_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_lo(cnt_lo), .cnt_mid(cnt_mid),
    .phase_len(phase_len), .cmd_phase(cmd_phase), .dma_en(dma_en), .sel_req(sel_req),
    .dev_empty(dev_empty), .burst_ack(burst_ack), .ack_bytes(ack_bytes),
    .irq_clear(irq_clear), .burst_req(burst_req), .burst_len(burst_len),
    .burst_to_dev(burst_to_dev), .done(done), .irq(irq), .tc_flag(tc_flag),
    .intr_reg(intr_reg), .rem_len(rem_len), .sel_go(sel_go)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1;
    tick();
    irq_clear = 1'b0;
    chk(irq == 1'b0 && intr_reg == 8'h00, "R9 irq cleared", {irq, intr_reg}, 0);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic run_xfer(input int cnt, input int p, input bit cmd, input int idx);
    int c, lim, el, ack, ra;
    bit td, ea, fin;
    string tag;
    c   = (cnt == 0) ? 65536 : cnt;
    lim = cmd ? 32 : ((p < 0) ? -p : p);
    el  = (c < lim) ? c : lim;
    td  = cmd || (p < 0);
    tag = (cnt == 0 || cnt > 255) ? "R1 count" : (cmd ? "R2 cmd length" : "R3 phase length");
    cnt_lo = cnt[7:0]; cnt_mid = cnt[15:8]; phase_len = 24'(p); cmd_phase = cmd;
    dev_empty = 1'b1; start = 1'b1;
    tick();
    start = 1'b0;
    if (el == 0) begin
      chk(done == 1'b1, "R10 zero length done", done, 1);
      chk(tc_flag && irq && intr_reg == 8'h10 && burst_len == 0, "R10 zero length regs",
          {tc_flag, irq, intr_reg}, {1'b1, 1'b1, 8'h10});
      chk(burst_req == 1'b0, "R10 no request", burst_req, 0);
      clear_irq();
      return;
    end
    chk(tc_flag == 1'b0 && done == 1'b0, "R4 tc cleared", {tc_flag, done}, 0);
    chk(burst_len == 17'(el), tag, burst_len, el);
    chk(burst_to_dev == td, cmd ? "R2 direction" : "R3 direction", burst_to_dev, td);
    chk(burst_req == 1'b0, "R5 waits while empty", burst_req, 0);
    dev_empty = 1'b0;
    #1;
    chk(burst_req == 1'b1, "R5 request when data", burst_req, 1);
    ack = (idx % 3 == 1 && el > 1) ? el - 1 : el;
    ea  = (idx % 2 == 0);
    ra  = cmd ? p : (td ? p + ack : p - ack);
    fin = !ea || td || (el - ack) != 0 || ra == 0;
    burst_ack = 1'b1; ack_bytes = 17'(ack); dev_empty = ea;
    tick();
    burst_ack = 1'b0;
    chk(int'(rem_len) == ra, "R6 remaining length", int'(rem_len), ra);
    chk(done == fin, "R7 completion decision", done, fin);
    if (!fin) begin
      tick();
      chk(done == 1'b0 && burst_req == 1'b0, "R8 deferred quiet", {done, burst_req}, 0);
      dev_empty = 1'b0;
      tick();
      chk(done == 1'b1, "R8 deferred completes", done, 1);
    end
    chk(tc_flag && irq && intr_reg == 8'h10 && burst_len == 0, "R9 completion regs",
        {tc_flag, irq, intr_reg}, {1'b1, 1'b1, 8'h10});
    clear_irq();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnts[8] = '{0, 1, 5, 31, 32, 33, 300, 65535};
    int pls[8]  = '{-100000, -40, -1, 0, 1, 31, 40, 70000};
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(!tc_flag && !irq && !done && !burst_req && intr_reg == 0 && !sel_go,
        "R9 reset state", {tc_flag, irq, done, burst_req, sel_go}, 0);

    idx = 0;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          run_xfer(cnts[i], pls[j], m[0], idx);
          idx++;
        end

    // R11: selection with DMA enabled
    dma_en = 1'b1; sel_req = 1'b1;
    tick();
    sel_req = 1'b0;
    chk(sel_go == 1'b1, "R11 immediate release", sel_go, 1);
    tick();
    chk(sel_go == 1'b0, "R11 single pulse", sel_go, 0);
    // R11: selection held while disabled
    dma_en = 1'b0; sel_req = 1'b1;
    tick();
    sel_req = 1'b0;
    chk(sel_go == 1'b0, "R11 held when disabled", sel_go, 0);
    tick(); tick();
    chk(sel_go == 1'b0, "R11 still held", sel_go, 0);
    dma_en = 1'b1;
    tick();
    chk(sel_go == 1'b1, "R11 released on enable", sel_go, 1);
    tick();
    chk(sel_go == 1'b0, "R11 released once", sel_go, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule